// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management master for an Ethernet PHY. It reads and writes 16-bit PHY registers with Clause 22 frames on a two-wire MDC/MDIO link. It produces the MDC clock by dividing the module clock. It shifts each frame out on MDIO. When a frame is a read, it releases the line for the PHY's reply and returns the captured word to the host.

A single control register sets the link behaviour:
- a 6-bit divider code sets the MDC rate, and a code of zero switches MDC off;
- a 3-bit hold code sets how long MDIO stays unchanged after each falling MDC edge;
- a flag removes the 32-bit preamble from the start of each frame.

The host programs the register first. It then issues one command at a time on the command port. It waits for the one-cycle completion pulse, which comes together with the read data.

Top module: `mdio_master`

## Requirements
- R1: While the divider code `c` (control bits 6:1) is nonzero, MDC runs continuously with a period of exactly 2*(c+1) module clocks. It is high for c+1 clocks and low for c+1 clocks, whether or not a frame is in progress.
- R2: While the divider code is zero, MDC stays low and a command is not accepted: no frame is driven and no done pulse occurs.
- R3: A control register write loads the divider code from bits 6:1, the preamble-disable flag from bit 7 and the hold code from bits 10:8. A read returns those fields in the same places, with bit 0 and bits 31:11 reading as zero.
- R4: A frame, in send order and MSB first, is:
  - 32 one-bits of preamble;
  - start bits 0 then 1;
  - op code 01 for a write or 10 for a read;
  - the 5-bit PHY address;
  - the 5-bit register address;
  - two turnaround bits;
  - 16 data bits.
- R5: With the preamble-disable flag set, the frame begins directly with the start bits: no leading one-bits are driven.
- R6: On a write (`cmd_read`=0), the master drives MDIO (output enable high) for the whole frame, sends turnaround 1 then 0, and sends the 16 write-data bits MSB first.
- R7: On a read (`cmd_read`=1), output enable is low during both turnaround bits and all 16 data bits. MDIO-in is sampled on each rising MDC edge, and the 16 data-phase samples, first one as MSB, appear on `rd_data`.
- R8: With hold code h and the requirement h < c, each change of the driven MDIO value happens exactly h+1 module clocks after the falling MDC edge that precedes it.
- R9: A command presented while a frame is in progress is ignored: the running frame is unchanged and no further frame or done pulse follows it.
- R10: `done` is high for exactly one clock after the rising MDC edge that samples the last data bit, and `rd_data` is valid in that cycle. After `done`, output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write value |
| cfg_rdata | output | 32 | Control register read value |
| cmd_valid | input | 1 | Start-frame request, one cycle |
| cmd_read | input | 1 | 1 = read frame, 0 = write frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | Frame-complete pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value from the line |

## Verification
MDC timing is due relative to its own edges:
- a rise follows the previous rise after 2*(c+1) clocks;
- a fall follows a rise after c+1 clocks;
- a driven MDIO change lands h+1 clocks after the preceding fall.

The bench measures each of these intervals by counting clocks at the falling clock edge, so that sampling never coincides with the update edge. Frame bits are captured on the sample following each rising MDC edge, and the modelled PHY drives its reply bits during the MDC low phase. `done` and `rd_data` are read in the same sampled cycle. One cycle later, `done` and the output enable are checked to be low. Ignored commands are judged over a 300-cycle idle window that follows the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    MDIO_OP_WR = 2'b01,
    MDIO_OP_RD = 2'b10
  } mdio_op_e;

  localparam logic [1:0] MDIO_START  = 2'b01;
  localparam logic [1:0] MDIO_TA_WR  = 2'b10;
  localparam logic [1:0] MDIO_TA_REL = 2'b11;
endpackage

// File: rtl/mdio_cfg_reg.sv
module mdio_cfg_reg #(
  parameter int CFG_W  = 32,
  parameter int DIV_W  = 6,
  parameter int HOLD_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic [DIV_W-1:0]  div_code,
  output logic [HOLD_W-1:0] hold_code,
  output logic              pre_dis
);
  localparam int DIV_LSB  = 1;
  localparam int PD_BIT   = DIV_LSB + DIV_W;
  localparam int HOLD_LSB = PD_BIT + 1;
  localparam int TOP_BIT  = HOLD_LSB + HOLD_W;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[CFG_W-1:TOP_BIT], cfg_wdata[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      div_code  <= '0;
      hold_code <= '0;
      pre_dis   <= 1'b0;
    end else if (cfg_we) begin
      div_code  <= cfg_wdata[DIV_LSB +: DIV_W];
      hold_code <= cfg_wdata[HOLD_LSB +: HOLD_W];
      pre_dis   <= cfg_wdata[PD_BIT];
    end
  end

  always_comb begin
    cfg_rdata                     = '0;
    cfg_rdata[DIV_LSB +: DIV_W]   = div_code;
    cfg_rdata[PD_BIT]             = pre_dis;
    cfg_rdata[HOLD_LSB +: HOLD_W] = hold_code;
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (div_code == $past(cfg_wdata[DIV_LSB +: DIV_W]))
           && (hold_code == $past(cfg_wdata[HOLD_LSB +: HOLD_W]))); // R3
endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_code,
  output logic             mdc,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || div_code == '0) begin
      cnt    <= '0;
      mdc    <= 1'b0;
      rise_p <= 1'b0;
      fall_p <= 1'b0;
    end else begin
      rise_p <= 1'b0;
      fall_p <= 1'b0;
      if (cnt >= div_code) begin
        cnt    <= '0;
        mdc    <= ~mdc;
        rise_p <= ~mdc;
        fall_p <= mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_MDC_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    (div_code == '0) |=> !mdc); // R2
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int HOLD_W  = 3,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              pre_dis,
  input  logic [HOLD_W-1:0] hold_code,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [PHY_W-1:0]  cmd_phy,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  localparam int BODY   = 6 + PHY_W + REG_W + DATA_W;
  localparam int TOT    = PRE_LEN + BODY;
  localparam int IDX_W  = $clog2(TOT);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOT - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 4 + PHY_W + REG_W);
  localparam logic [IDX_W-1:0] BODY_IDX = IDX_W'(PRE_LEN);

  logic              busy, is_rd, started, last_out, pend, drv;
  logic [IDX_W-1:0]  idx;
  logic [HOLD_W-1:0] hcnt;
  logic [TOT-1:0]    frame_q, frame_w;
  logic [DATA_W-1:0] sh_in;

  always_comb begin
    frame_w = {{PRE_LEN{1'b1}}, MDIO_START,
               cmd_read ? MDIO_OP_RD : MDIO_OP_WR,
               cmd_phy, cmd_reg,
               cmd_read ? MDIO_TA_REL : MDIO_TA_WR,
               cmd_wdata};
    drv = busy && !last_out &&
          ((fall_p && hold_code == '0) || (pend && hcnt == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      is_rd    <= 1'b0;
      started  <= 1'b0;
      last_out <= 1'b0;
      pend     <= 1'b0;
      hcnt     <= '0;
      idx      <= '0;
      frame_q  <= '0;
      sh_in    <= '0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid && enable) begin
          busy     <= 1'b1;
          is_rd    <= cmd_read;
          started  <= 1'b0;
          last_out <= 1'b0;
          pend     <= 1'b0;
          hcnt     <= '0;
          frame_q  <= pre_dis ? (frame_w << PRE_LEN) : frame_w;
          idx      <= pre_dis ? BODY_IDX : '0;
        end
      end else begin
        if (drv) begin
          mdio_o  <= frame_q[TOT-1];
          frame_q <= {frame_q[TOT-2:0], 1'b0};
          mdio_oe <= !(is_rd && idx >= TA_IDX);
          started <= 1'b1;
          if (idx == LAST_IDX) last_out <= 1'b1;
          else                 idx      <= idx + 1'b1;
        end
        if (fall_p && !last_out && hold_code != '0) begin
          pend <= 1'b1;
          hcnt <= hold_code - 1'b1;
        end else if (pend) begin
          if (hcnt == '0) pend <= 1'b0;
          else            hcnt <= hcnt - 1'b1;
        end
        if (rise_p && started) begin
          sh_in <= {sh_in[DATA_W-2:0], mdio_i};
          if (last_out) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
            if (is_rd) rd_data <= {sh_in[DATA_W-2:0], mdio_i};
          end
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe); // R10
  AST_NO_START_OFF: assert property (@(posedge clk) disable iff (rst)
    (!busy && !enable) |=> !busy); // R2
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && idx > TA_IDX) |-> !mdio_oe); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> $stable(is_rd)); // R9
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int CFG_W   = 32,
  parameter int DIV_W   = 6,
  parameter int HOLD_W  = 3,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [PHY_W-1:0]  cmd_phy,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [DIV_W-1:0]  div_code;
  logic [HOLD_W-1:0] hold_code;
  logic              pre_dis, rise_p, fall_p;

  mdio_cfg_reg #(.CFG_W(CFG_W), .DIV_W(DIV_W), .HOLD_W(HOLD_W)) cfg_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .div_code(div_code), .hold_code(hold_code),
    .pre_dis(pre_dis));

  mdio_mdc_gen #(.DIV_W(DIV_W)) mdc_i (
    .clk(clk), .rst(rst), .div_code(div_code),
    .mdc(mdc), .rise_p(rise_p), .fall_p(fall_p));

  mdio_frame_eng #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W),
                   .HOLD_W(HOLD_W), .PRE_LEN(PRE_LEN)) eng_i (
    .clk(clk), .rst(rst), .enable(div_code != '0), .pre_dis(pre_dis),
    .hold_code(hold_code), .rise_p(rise_p), .fall_p(fall_p),
    .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_phy(cmd_phy),
    .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data), .done(done));

  AST_MDC_MIN_HALF: assert property (@(posedge clk) disable iff (rst)
    ($rose(mdc) && div_code != '0 && !cfg_we) |=> mdc); // R1
  AST_MDIO_CHANGE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_o) && HOLD_W'(hold_code) < DIV_W'(div_code)) |-> !mdc); // R8
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [4:0]  cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic [15:0] rd_data;
  logic        done, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  mdio_master dut_i (.clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .rd_data(rd_data), .done(done), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  // {div[36:31], hold[30:28], no_pre[27], read[26], phy[25:21], reg[20:16], data[15:0]}
  localparam logic [36:0] VECS [0:6] = '{
    {6'd30, 3'd3, 1'b0, 1'b0, 5'h01, 5'h04, 16'hA5C3},
    {6'd30, 3'd3, 1'b0, 1'b1, 5'h01, 5'h01, 16'h7809},
    {6'd1,  3'd0, 1'b0, 1'b1, 5'h1F, 5'h1F, 16'hFFFF},
    {6'd2,  3'd1, 1'b1, 1'b0, 5'h00, 5'h00, 16'h0000},
    {6'd63, 3'd7, 1'b0, 1'b1, 5'h12, 5'h0A, 16'h8001},
    {6'd5,  3'd4, 1'b1, 1'b1, 5'h07, 5'h13, 16'h1234},
    {6'd3,  3'd2, 1'b0, 1'b0, 5'h1E, 5'h15, 16'hFFFF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] val);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = val;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic issue(input bit rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] dat);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = dat;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Watch for n cycles: count MDC rises, output-enable cycles and done pulses.
  task automatic idle_watch(input int n, output int rises, output int oes, output int dones);
    logic pm;
    rises = 0; oes = 0; dones = 0; pm = mdc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mdc && !pm) rises++;
      if (mdio_oe) oes++;
      if (done) dones++;
      pm = mdc;
    end
  endtask

  task automatic run_vec(input logic [36:0] v, input bit inject);
    logic [5:0] dv; logic [2:0] hd; logic pd, rd; logic [4:0] phy, rg; logic [15:0] dat;
    int pre_cnt, pos, last_rise, fcnt, per_err, hold_err, hold_seen, oe_err, tcyc, got_done;
    int rises, oes, dones;
    logic [12:0] hdr; logic [1:0] ta; logic [15:0] wcap, rcap;
    logic pm, po, poe; bit in_frame, injected;
    {dv, hd, pd, rd, phy, rg, dat} = v;
    write_cfg({21'd0, hd, pd, dv, 1'b0});
    repeat (300) @(negedge clk);
    issue(rd, phy, rg, dat);
    pre_cnt = 0; pos = 0; last_rise = -1; fcnt = 0; per_err = 0; hold_err = 0;
    hold_seen = 0; oe_err = 0; tcyc = 0; got_done = 0; hdr = '0; ta = '0;
    wcap = '0; rcap = '0; in_frame = 0; injected = 0;
    pm = mdc; po = mdio_o; poe = mdio_oe;
    while (!got_done && tcyc < 20000) begin
      @(negedge clk);
      tcyc++;
      if (inject) begin
        if (injected && cmd_valid) cmd_valid = 1'b0;
        if (!injected && pos == 20) begin
          cmd_valid = 1'b1; cmd_read = ~rd; cmd_phy = 5'h0A; cmd_reg = 5'h05;
          cmd_wdata = 16'h5555; injected = 1;
        end
      end
      if (!mdc && pm) fcnt = 0; else fcnt++;
      if (mdio_oe && poe && mdio_o != po) begin
        hold_seen++;
        if (fcnt != hd + 1) hold_err++;
      end
      if (mdc && !pm) begin
        if (last_rise >= 0 && tcyc - last_rise != 2 * (dv + 1)) per_err++;
        last_rise = tcyc;
        if (!in_frame) begin
          if (mdio_oe) begin
            if (mdio_o) pre_cnt++;
            else begin in_frame = 1; pos = 1; end
          end
        end else if (pos <= 31) begin
          if (pos <= 13) begin
            hdr = {hdr[11:0], mdio_o};
            if (!mdio_oe) oe_err++;
          end else begin
            if (pos <= 15) ta = {ta[0], mdio_o};
            else wcap = {wcap[14:0], mdio_o};
            if (rd && mdio_oe) oe_err++;
            if (!rd && !mdio_oe) oe_err++;
          end
          pos++;
        end
      end
      if (!mdc && pm) begin
        if (last_rise >= 0 && tcyc - last_rise != dv + 1) per_err++;
        if (rd && in_frame && pos == 15) mdio_i = 1'b0;
        else if (rd && in_frame && pos >= 16 && pos <= 31) mdio_i = dat[31 - pos];
        else mdio_i = 1'b1;
      end
      if (done) begin got_done = 1; rcap = rd_data; end
      pm = mdc; po = mdio_o; poe = mdio_oe;
    end
    cmd_valid = 1'b0;
    chk(got_done == 1, "R10 done seen", got_done, 1);
    chk(pre_cnt == (pd ? 0 : 32), pd ? "R5 preamble length" : "R4 preamble length", pre_cnt, pd ? 0 : 32);
    chk(hdr == {1'b1, (rd ? 2'b10 : 2'b01), phy, rg}, "R4 start/op/addr", hdr, {1'b1, (rd ? 2'b10 : 2'b01), phy, rg});
    chk(pos == 32, "R4 frame length", pos, 32);
    if (rd) begin
      chk(rcap == dat, "R7 read data", rcap, dat);
      chk(oe_err == 0, "R7 release in ta/data", oe_err, 0);
    end else begin
      chk(ta == 2'b10, "R6 turnaround", ta, 2'b10);
      chk(wcap == dat, "R6 write data", wcap, dat);
      chk(oe_err == 0, "R6 drive enable", oe_err, 0);
    end
    chk(hold_err == 0 && hold_seen > 0, "R8 hold delay", hold_err, 0);
    chk(per_err == 0, "R1 mdc period/duty", per_err, 0);
    @(negedge clk);
    chk(!done && !mdio_oe, "R10 done width/oe low", {done, mdio_oe}, 0);
    idle_watch(300, rises, oes, dones);
    chk(rises >= 1, "R1 mdc free-running idle", rises, 1);
    if (inject) chk(oes == 0 && dones == 0, "R9 busy command ignored", {oes[15:0], dones[15:0]}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  initial begin
    int rises, oes, dones;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(cfg_rdata == 0, "R3 reset cfg", cfg_rdata, 0);
    chk(!mdc && !mdio_oe && !done, "R2 reset outputs", {mdc, mdio_oe, done}, 0);
    issue(1'b1, 5'h01, 5'h02, 16'h0);
    idle_watch(200, rises, oes, dones);
    chk(rises == 0 && !mdc, "R2 mdc off at code 0", rises, 0);
    chk(oes == 0 && dones == 0, "R2 command ignored at code 0", {oes[15:0], dones[15:0]}, 0);
    write_cfg(32'hFFFF_FFFF);
    @(negedge clk);
    chk(cfg_rdata == 32'h0000_07FE, "R3 field readback", cfg_rdata, 32'h7FE);
    write_cfg(32'h0000_0000);
    @(negedge clk);
    chk(cfg_rdata == 32'h0, "R3 clear readback", cfg_rdata, 0);
    for (int k = 0; k < 7; k++) run_vec(VECS[k], k == 1 || k == 4);
    write_cfg(32'h0);
    @(negedge clk);
    issue(1'b0, 5'h03, 5'h03, 16'hBEEF);
    idle_watch(200, rises, oes, dones);
    chk(rises == 0 && !mdc && oes == 0 && dones == 0, "R2 stop after running", rises, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule